// File: doc/BRIEF.md
# Split-Field Next-PC Calculator

This block computes the address of the next sequential instruction in a fetch stage that handles instructions of 1, 2, 5 or 6 bytes. It takes the current program counter and two decode flags. One flag marks an instruction that carries a register-specifier byte. The other marks an instruction that carries a 4-byte constant. From these it forms the instruction length and adds it to the PC.

To keep the add off the critical path, the PC is split into a 3-bit low field and a 29-bit high field. The high field is incremented as soon as the PC is known, in parallel with the instruction memory read, because this increment does not depend on the flags. At the end of the cycle, a short 3-bit add of the low field and the length produces a carry. That carry selects either the unchanged or the incremented high field. A parameter can instead select a single full-width adder.

A registered copy of the result, qualified by a valid strobe, is provided so that a pipeline can capture it each cycle. The registered result holds its value when the strobe is low.

Top module: `pcinc_fast`

## Requirements
- R1: `insn_len` equals 1, plus 1 when `has_regbyte` is high, plus 4 when `has_const` is high. The only possible lengths are therefore 1, 2, 5 and 6.
- R2: `next_pc` equals `pc + insn_len` modulo 2^32, for every flag combination.
- R3: `next_pc[2:0]` equals `(pc[2:0] + insn_len) mod 8`.
- R4: `next_pc[31:3]` equals `pc[31:3]` plus 1 exactly when `pc[2:0] + insn_len >= 8`. Otherwise it equals `pc[31:3]` unchanged.
- R5: Near the top of the address space the result wraps to a low address and no error is raised (0xFFFFFFFF with length 1 gives 0x00000000).
- R6: One clock after a cycle with `in_valid` high, `next_pc_q` equals that cycle's `next_pc`, and `out_valid` follows `in_valid` with one cycle of delay.
- R7: While `rst_n` is low, `out_valid` and `next_pc_q` are 0.
- R8: A cycle with `in_valid` low leaves `next_pc_q` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Capture strobe for the registered result |
| pc | input | 32 | Current program counter |
| has_regbyte | input | 1 | Instruction carries a register-specifier byte |
| has_const | input | 1 | Instruction carries a 4-byte constant |
| insn_len | output | 3 | Decoded instruction length in bytes |
| next_pc | output | 32 | Combinational next sequential PC |
| next_pc_q | output | 32 | Registered next PC |
| out_valid | output | 1 | Registered strobe for next_pc_q |

## Verification
A wrong carry select shows at the ports in the same cycle. When it happens, `next_pc` is off by exactly 8 while its low three bits stay correct. It can only appear when the low field plus the length crosses 8, so the sweep covers every low-field value from 0 to 7 under each flag pair. An error in the length encoder shows in the same cycle on both `insn_len` and `next_pc`. A fault in the output register appears one clock later on `next_pc_q`, either as a missed capture or as a value that changes during a hold cycle.

// File: rtl/pcinc_pkg.sv
package pcinc_pkg;
    localparam int unsigned PC_W        = 32;
    localparam int unsigned LOW_W       = 3;
    localparam int unsigned BASE_BYTES  = 1;
    localparam int unsigned REG_BYTES   = 1;
    localparam int unsigned CONST_BYTES = 4;
endpackage

// File: rtl/pcinc_len_enc.sv
module pcinc_len_enc #(
    parameter int unsigned LOW_W       = pcinc_pkg::LOW_W,
    parameter int unsigned BASE_BYTES  = pcinc_pkg::BASE_BYTES,
    parameter int unsigned REG_BYTES   = pcinc_pkg::REG_BYTES,
    parameter int unsigned CONST_BYTES = pcinc_pkg::CONST_BYTES
) (
    input  logic             has_regbyte,
    input  logic             has_const,
    output logic [LOW_W-1:0] len
);
    localparam logic [LOW_W-1:0] BASE_L  = LOW_W'(BASE_BYTES);
    localparam logic [LOW_W-1:0] REG_L   = LOW_W'(REG_BYTES);
    localparam logic [LOW_W-1:0] CONST_L = LOW_W'(CONST_BYTES);

    // Summing the parts in LOW_W bits is safe: the largest sum, 6, fits in 3 bits.
    always_comb begin
        len = BASE_L;
        if (has_regbyte) len = len + REG_L;
        if (has_const)   len = len + CONST_L;
    end
endmodule

// File: rtl/pcinc_low_add.sv
module pcinc_low_add #(
    parameter int unsigned LOW_W = pcinc_pkg::LOW_W
) (
    input  logic [LOW_W-1:0] low_in,
    input  logic [LOW_W-1:0] addend,
    output logic [LOW_W-1:0] sum,
    output logic             carry
);
    logic [LOW_W:0] wide;

    always_comb begin
        wide  = {1'b0, low_in} + {1'b0, addend};
        sum   = wide[LOW_W-1:0];
        carry = wide[LOW_W];
    end
endmodule

// File: rtl/pcinc_high_inc.sv
module pcinc_high_inc #(
    parameter int unsigned HIGH_W = pcinc_pkg::PC_W - pcinc_pkg::LOW_W
) (
    input  logic [HIGH_W-1:0] high_in,
    output logic [HIGH_W-1:0] high_p1
);
    // Depends only on the PC, so it settles while the memory read is in flight.
    always_comb high_p1 = high_in + HIGH_W'(1);
endmodule

// File: rtl/pcinc_fast.sv
module pcinc_fast #(
    parameter int unsigned PC_W       = pcinc_pkg::PC_W,
    parameter int unsigned LOW_W      = pcinc_pkg::LOW_W,
    parameter bit          SPLIT_ADD  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [PC_W-1:0]  pc,
    input  logic             has_regbyte,
    input  logic             has_const,
    output logic [LOW_W-1:0] insn_len,
    output logic [PC_W-1:0]  next_pc,
    output logic [PC_W-1:0]  next_pc_q,
    output logic             out_valid
);
    localparam int unsigned HIGH_W = PC_W - LOW_W;

    typedef struct packed {
        logic            vld;
        logic [PC_W-1:0] npc;
    } state_t;

    state_t state_d, state_q;
    logic [LOW_W-1:0] len_w;
    logic [PC_W-1:0]  sum_w;

    pcinc_len_enc #(.LOW_W(LOW_W)) i_len (
        .has_regbyte (has_regbyte),
        .has_const   (has_const),
        .len         (len_w)
    );

    generate
        if (SPLIT_ADD) begin : g_split
            logic [LOW_W-1:0]  low_sum;
            logic              low_carry;
            logic [HIGH_W-1:0] high_p1;

            pcinc_high_inc #(.HIGH_W(HIGH_W)) i_hi (
                .high_in (pc[PC_W-1:LOW_W]),
                .high_p1 (high_p1)
            );

            pcinc_low_add #(.LOW_W(LOW_W)) i_lo (
                .low_in (pc[LOW_W-1:0]),
                .addend (len_w),
                .sum    (low_sum),
                .carry  (low_carry)
            );

            // The late-arriving low carry drives only this select.
            always_comb sum_w = {low_carry ? high_p1 : pc[PC_W-1:LOW_W], low_sum};
        end else begin : g_flat
            always_comb sum_w = pc + PC_W'(len_w);
        end
    endgenerate

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) state_d.npc = sum_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign insn_len  = len_w;
    assign next_pc   = sum_w;
    assign next_pc_q = state_q.npc;
    assign out_valid = state_q.vld;
endmodule

// File: rtl/pcinc_fast_chk.sv
module pcinc_fast_chk #(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned LOW_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [PC_W-1:0]  pc,
    input logic             has_regbyte,
    input logic             has_const,
    input logic [LOW_W-1:0] insn_len,
    input logic [PC_W-1:0]  next_pc,
    input logic [PC_W-1:0]  next_pc_q,
    input logic             out_valid
);
    // R1
    p_len_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        insn_len == 3'd1 || insn_len == 3'd2 || insn_len == 3'd5 || insn_len == 3'd6);

    // R1: a constant always makes the length at least 5.
    p_const_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
        has_const |-> insn_len >= 3'd5);

    // R2
    p_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
        next_pc == pc + PC_W'(insn_len));

    // R4: the high field moves by 0 or 1 only.
    p_high_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (next_pc[PC_W-1:LOW_W] == pc[PC_W-1:LOW_W]) ||
        (next_pc[PC_W-1:LOW_W] == pc[PC_W-1:LOW_W] + (PC_W-LOW_W)'(1)));

    // R6
    p_valid_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    // R6
    p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> next_pc_q == $past(next_pc));

    // R8
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(next_pc_q));
endmodule

bind pcinc_fast pcinc_fast_chk #(.PC_W(PC_W), .LOW_W(LOW_W)) i_pcinc_fast_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .pc          (pc),
    .has_regbyte (has_regbyte),
    .has_const   (has_const),
    .insn_len    (insn_len),
    .next_pc     (next_pc),
    .next_pc_q   (next_pc_q),
    .out_valid   (out_valid)
);

// File: tb/test_pcinc_fast.sv
`timescale 1ns/1ps
module test_pcinc_fast;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] pc = '0;
    logic        has_regbyte = 1'b0;
    logic        has_const = 1'b0;
    logic [2:0]  insn_len;
    logic [31:0] next_pc;
    logic [31:0] next_pc_q;
    logic        out_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pcinc_fast i_pcinc_fast (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .pc          (pc),
        .has_regbyte (has_regbyte),
        .has_const   (has_const),
        .insn_len    (insn_len),
        .next_pc     (next_pc),
        .next_pc_q   (next_pc_q),
        .out_valid   (out_valid)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_len(input bit r, input bit c);
        return 32'd1 + (r ? 32'd1 : 32'd0) + (c ? 32'd4 : 32'd0);
    endfunction

    // Apply one PC and flag pair. Check the combinational outputs, then the registered ones.
    task automatic apply(input logic [31:0] p, input bit r, input bit c);
        logic [31:0] exp_len, exp_pc, exp_hi;
        logic [3:0]  low_sum;
        @(negedge clk);
        pc = p; has_regbyte = r; has_const = c; in_valid = 1'b1;
        exp_len = ref_len(r, c);
        exp_pc  = p + exp_len;
        low_sum = {1'b0, p[2:0]} + exp_len[3:0];
        exp_hi  = {3'b0, p[31:3]} + (low_sum[3] ? 32'd1 : 32'd0);
        #1;
        check(32'(insn_len) == exp_len, "R1", 32'(insn_len), exp_len);
        check(next_pc == exp_pc, "R2", next_pc, exp_pc);
        check(32'(next_pc[2:0]) == 32'(low_sum[2:0]), "R3", 32'(next_pc[2:0]), 32'(low_sum[2:0]));
        check({3'b0, next_pc[31:3]} == (exp_hi & 32'h1FFF_FFFF), "R4",
              {3'b0, next_pc[31:3]}, exp_hi & 32'h1FFF_FFFF);
        @(negedge clk);
        in_valid = 1'b0;
        check(next_pc_q == exp_pc, "R6", next_pc_q, exp_pc);
        check(out_valid == 1'b1, "R6", 32'(out_valid), 32'd1);
    endtask

    task automatic t_reset();
        #1;
        check(out_valid == 1'b0, "R7", 32'(out_valid), 32'd0);
        check(next_pc_q == 32'd0, "R7", next_pc_q, 32'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_flag_table();
        for (int k = 0; k < 4; k++) apply(32'h0000_1000, k[0], k[1]);
    endtask

    task automatic t_carry_sweep();
        for (int lo = 0; lo < 8; lo++)
            for (int k = 0; k < 4; k++)
                apply(32'h1234_5670 | 32'(lo), k[0], k[1]);
    endtask

    task automatic t_wrap();
        apply(32'hFFFF_FFFF, 1'b0, 1'b0);
        check(next_pc_q == 32'h0000_0000, "R5", next_pc_q, 32'h0000_0000);
        apply(32'hFFFF_FFFC, 1'b1, 1'b1);
        check(next_pc_q == 32'h0000_0002, "R5", next_pc_q, 32'h0000_0002);
    endtask

    task automatic t_random();
        int unsigned s;
        for (int n = 0; n < 200; n++) begin
            s = $urandom();
            apply(s, n[0], n[1]);
        end
    endtask

    task automatic t_hold();
        logic [31:0] held;
        apply(32'h0000_0106, 1'b1, 1'b1);
        held = 32'h0000_010C;
        @(negedge clk);
        pc = 32'hABCD_0007; has_regbyte = 1'b1; has_const = 1'b1; in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(next_pc_q == held, "R8", next_pc_q, held);
        check(out_valid == 1'b0, "R6", 32'(out_valid), 32'd0);
    endtask

    initial begin
        t_reset();
        t_flag_table();
        t_carry_sweep();
        t_wrap();
        t_random();
        t_hold();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule